// File: doc/BRIEF.md
# Receive Buffer Descriptor Writer

This block sits between a receive frame pipeline and the logic that writes descriptors back to host memory. Each received frame arrives as one beat per byte, with markers for its first and last byte. The byte data travels on a separate path, so only the markers and the per-buffer side information pass through here. The block lays the frame over one or more fixed-size receive buffers. For each buffer it fills or closes, it emits a single 128-bit descriptor write-back.

The buffer size comes from the queue's own size field when that field is nonzero. Otherwise a global size code applies. The size in force is captured once per frame, on its first byte. Each write-back carries the following:

- the address of that buffer
- the number of bytes placed in it
- the packet checksum, supplied by a separate checksum engine and carried only in the first descriptor of the frame
- a done flag, plus an end-of-frame flag on the last descriptor
- error bits and a VLAN tag, taken with the byte that closes the buffer

A write-back is offered with valid and ready. The byte stream is held off until it is taken. Only the legacy descriptor type is handled.

Top module: `rxd_writer`

## Requirements
- R1: When the per-queue size field is zero, the buffer size follows the global 2-bit code: 0 gives 2048 bytes, 1 gives 1024, 2 gives 512 and 3 gives 256.
- R2: When the per-queue size field is nonzero, the buffer size is that value times 1024 bytes, whatever the global code says.
- R3: The buffer size is captured on the first byte of a frame (`byte_sof` high) and holds for the whole frame, even if the size inputs change later in the frame.
- R4: Bytes are accepted only when the queue descriptor type is 3'b000. For any other type, `byte_ready` stays low, no byte is counted and no write-back is produced.
- R5: The write-back layout is as follows. Bits [63:0] hold the buffer address, [79:64] the length, [95:80] the checksum, [103:96] the status, [111:104] the errors and [127:112] the VLAN tag. The errors and VLAN tag are the `rx_err` and `rx_vlan` values present with the byte that closes the buffer.
- R6: A buffer closes on the byte that fills it to the buffer size, or on the frame's last byte, whichever comes first. The length field equals the number of bytes placed in that buffer alone.
- R7: The checksum field holds `pkt_csum` (sampled on the closing byte of the first buffer) in the first descriptor of a frame, and zero in every later descriptor of that frame.
- R8: Status bit 0 (done) is set in every write-back. Status bit 1 (end of frame) is set only in the last descriptor of a frame. Status bits 7:2 are zero.
- R9: The address field is the `buf_addr` value present with the first byte of that buffer. Any byte alignment is allowed, and later values on `buf_addr` within the buffer are ignored.
- R10: A write-back appears in the cycle after its closing byte is accepted. `wb_valid` and `wb_desc` stay unchanged until `wb_ready` is seen, and `byte_ready` is low while `wb_valid` is high.
- R11: After reset, `wb_valid` is low and `byte_ready` is high when the descriptor type is 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gsize_code | input | 2 | Global buffer size code |
| q_bsize | input | QSZ_W | Per-queue buffer size in 1 KB units, 0 selects global |
| q_dtype | input | 3 | Per-queue descriptor type, 3'b000 is legacy |
| byte_valid | input | 1 | A frame byte is present |
| byte_ready | output | 1 | The byte is accepted this cycle |
| byte_sof | input | 1 | First byte of a frame |
| byte_eop | input | 1 | Last byte of a frame |
| buf_addr | input | 64 | Address of the buffer that the next new buffer uses |
| pkt_csum | input | 16 | Packet checksum from the checksum engine |
| rx_err | input | 8 | Error bits for the closing buffer |
| rx_vlan | input | 16 | VLAN tag for the closing buffer |
| wb_valid | output | 1 | Descriptor write-back offered |
| wb_ready | input | 1 | Descriptor write-back taken |
| wb_desc | output | 128 | Descriptor write-back contents |

## Verification
Each fault in internal state shows in the next write-back at the latest.

- A byte counter that is off by one, or a size captured at the wrong time, gives a wrong length field. It can also place the end-of-frame flag in the wrong descriptor.
- A first-buffer flag that is stuck, or that is not cleared after the first buffer, moves the checksum into the wrong descriptor.
- An address latch that follows the input instead of holding its value shows as a wrong address. This is because the bench changes `buf_addr` on every non-first byte.

Handshake faults show in the single stall cycle the bench inserts after each write-back, through `byte_ready` and through whether the descriptor stays unchanged.

// File: rtl/rxd_pkg.sv
// Package: shared constants and the write-back descriptor type for the
// receive descriptor writer. Assumes the legacy 128-bit layout.
package rxd_pkg;
    localparam int ADDR_W   = 64;
    localparam int LEN_W    = 16;
    localparam int CSUM_W   = 16;
    localparam int STAT_W   = 8;
    localparam int ERR_W    = 8;
    localparam int VLAN_W   = 16;
    localparam int DESC_W   = ADDR_W + LEN_W + CSUM_W + STAT_W + ERR_W + VLAN_W;
    localparam int KB_SHIFT = 10;
    localparam logic [2:0] DTYPE_LEGACY = 3'b000;
    localparam int ST_DONE  = 0;
    localparam int ST_EOF   = 1;
    localparam int DESC_DONE_BIT = ADDR_W + LEN_W + CSUM_W + ST_DONE;
    localparam int DESC_EOF_BIT  = ADDR_W + LEN_W + CSUM_W + ST_EOF;

    // Packed MSB first: vlan[127:112] err[111:104] status[103:96]
    // csum[95:80] len[79:64] addr[63:0]
    typedef struct packed {
        logic [VLAN_W-1:0] vlan;
        logic [ERR_W-1:0]  err;
        logic [STAT_W-1:0] status;
        logic [CSUM_W-1:0] csum;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] addr;
    } rx_desc_t;
endpackage

// File: rtl/rxd_size_sel.sv
// Module: buffer size selection. Picks the per-queue size (1 KB units) when
// nonzero, otherwise decodes the 2-bit global code. Purely combinational.
// Assumes SZ_W is wide enough for the largest per-queue size and 2048.
module rxd_size_sel #(
    parameter int QSZ_W = 4,
    parameter int SZ_W  = 14
) (
    input  logic [1:0]       gsize_code,
    input  logic [QSZ_W-1:0] q_bsize,
    output logic [SZ_W-1:0]  bufsz
);
    import rxd_pkg::*;

    logic [SZ_W-1:0] gsz;

    // Decode the global code into a byte count (halving per step).
    always_comb begin
        case (gsize_code)
            2'd0:    gsz = SZ_W'(2048);
            2'd1:    gsz = SZ_W'(1024);
            2'd2:    gsz = SZ_W'(512);
            default: gsz = SZ_W'(256);
        endcase
    end

    // Per-queue value wins when nonzero.
    always_comb begin
        if (q_bsize == '0) bufsz = gsz;
        else               bufsz = SZ_W'({q_bsize, {KB_SHIFT{1'b0}}});
    end
endmodule

// File: rtl/rxd_splitter.sv
// Module: frame splitter. Counts accepted bytes inside the current buffer,
// decides when a buffer closes (full or end of frame) and reports the
// closing length, first-buffer flag, end flag and buffer address.
// Assumes every frame starts with a byte marked sof.
module rxd_splitter #(
    parameter int SZ_W = 14
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fire,
    input  logic                      sof,
    input  logic                      eop,
    input  logic [SZ_W-1:0]           size_now,
    input  logic [rxd_pkg::ADDR_W-1:0] buf_addr,
    output logic                      close,
    output logic [SZ_W-1:0]           close_len,
    output logic                      close_first,
    output logic                      close_eop,
    output logic [rxd_pkg::ADDR_W-1:0] close_addr
);
    import rxd_pkg::*;

    logic [SZ_W-1:0]   cnt_q;
    logic [SZ_W-1:0]   size_q;
    logic [ADDR_W-1:0] addr_q;
    logic              first_q;

    logic [SZ_W-1:0]   size_eff;
    logic [SZ_W-1:0]   cnt_nx;
    logic              at_start;
    logic              hit_end;

    // Effective size, address and close decision for the byte on the input.
    always_comb begin
        at_start    = (cnt_q == '0);
        size_eff    = sof ? size_now : size_q;
        cnt_nx      = cnt_q + SZ_W'(1);
        hit_end     = eop || (cnt_nx == size_eff);
        close       = fire && hit_end;
        close_len   = cnt_nx;
        close_first = sof || first_q;
        close_eop   = eop;
        close_addr  = at_start ? buf_addr : addr_q;
    end

    // Byte counter, frame size capture, address latch and first-buffer flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            size_q  <= '0;
            addr_q  <= '0;
            first_q <= 1'b1;
        end else if (fire) begin
            if (sof) size_q <= size_now;
            addr_q <= close_addr;
            if (hit_end) begin
                cnt_q   <= '0;
                first_q <= eop;
            end else begin
                cnt_q   <= cnt_nx;
                first_q <= close_first;
            end
        end
    end

    // Count inside a buffer never reaches the captured size.
    p_cnt_below_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (cnt_q < size_q));
endmodule

// File: rtl/rxd_packer.sv
// Module: descriptor packer and write-back handshake. Builds the 128-bit
// descriptor on a close event and holds it until the consumer takes it.
// Assumes no close arrives while a write-back is pending.
module rxd_packer #(
    parameter int SZ_W = 14
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       close,
    input  logic [SZ_W-1:0]            close_len,
    input  logic                       close_first,
    input  logic                       close_eop,
    input  logic [rxd_pkg::ADDR_W-1:0] close_addr,
    input  logic [rxd_pkg::CSUM_W-1:0] pkt_csum,
    input  logic [rxd_pkg::ERR_W-1:0]  rx_err,
    input  logic [rxd_pkg::VLAN_W-1:0] rx_vlan,
    input  logic                       wb_ready,
    output logic                       wb_valid,
    output logic [rxd_pkg::DESC_W-1:0] wb_desc
);
    import rxd_pkg::*;

    rx_desc_t desc_q;
    rx_desc_t desc_nx;

    // Assemble the descriptor fields for the closing buffer.
    always_comb begin
        desc_nx         = '0;
        desc_nx.addr    = close_addr;
        desc_nx.len     = LEN_W'(close_len);
        desc_nx.csum    = close_first ? pkt_csum : '0;
        desc_nx.status[ST_DONE] = 1'b1;
        desc_nx.status[ST_EOF]  = close_eop;
        desc_nx.err     = rx_err;
        desc_nx.vlan    = rx_vlan;
    end

    // Write-back register: load on close, drop valid once taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            desc_q   <= '0;
        end else if (close) begin
            wb_valid <= 1'b1;
            desc_q   <= desc_nx;
        end else if (wb_valid && wb_ready) begin
            wb_valid <= 1'b0;
        end
    end

    assign wb_desc = desc_q;

    // Pending write-back holds its contents until taken.
    p_hold_until_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_desc)));

    // The splitter never closes a buffer while a write-back is pending.
    p_no_close_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !close);
endmodule

// File: rtl/rxd_writer.sv
// Module: receive buffer descriptor writer (top). Splits a received frame
// over fixed-size buffers and emits one legacy descriptor per buffer.
// Assumes QSZ_W <= 6 so that every buffer size fits the 16-bit length field.
module rxd_writer #(
    parameter int QSZ_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 gsize_code,
    input  logic [QSZ_W-1:0]           q_bsize,
    input  logic [2:0]                 q_dtype,
    input  logic                       byte_valid,
    output logic                       byte_ready,
    input  logic                       byte_sof,
    input  logic                       byte_eop,
    input  logic [63:0]                buf_addr,
    input  logic [15:0]                pkt_csum,
    input  logic [7:0]                 rx_err,
    input  logic [15:0]                rx_vlan,
    output logic                       wb_valid,
    input  logic                       wb_ready,
    output logic [127:0]               wb_desc
);
    import rxd_pkg::*;

    localparam int Q_MAX_B = ((1 << QSZ_W) - 1) << KB_SHIFT;
    localparam int SZ_MAX  = (Q_MAX_B > 2048) ? Q_MAX_B : 2048;
    localparam int SZ_W    = $clog2(SZ_MAX + 1);

    logic [SZ_W-1:0]   size_now;
    logic              fire;
    logic              close;
    logic [SZ_W-1:0]   close_len;
    logic              close_first;
    logic              close_eop;
    logic [ADDR_W-1:0] close_addr;

    // Accept bytes only for legacy descriptors and with no write-back pending.
    always_comb begin
        byte_ready = (q_dtype == DTYPE_LEGACY) && !wb_valid;
        fire       = byte_valid && byte_ready;
    end

    rxd_size_sel #(.QSZ_W(QSZ_W), .SZ_W(SZ_W)) u_size (
        .gsize_code (gsize_code),
        .q_bsize    (q_bsize),
        .bufsz      (size_now)
    );

    rxd_splitter #(.SZ_W(SZ_W)) u_split (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (fire),
        .sof         (byte_sof),
        .eop         (byte_eop),
        .size_now    (size_now),
        .buf_addr    (buf_addr),
        .close       (close),
        .close_len   (close_len),
        .close_first (close_first),
        .close_eop   (close_eop),
        .close_addr  (close_addr)
    );

    rxd_packer #(.SZ_W(SZ_W)) u_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .close       (close),
        .close_len   (close_len),
        .close_first (close_first),
        .close_eop   (close_eop),
        .close_addr  (close_addr),
        .pkt_csum    (pkt_csum),
        .rx_err      (rx_err),
        .rx_vlan     (rx_vlan),
        .wb_ready    (wb_ready),
        .wb_valid    (wb_valid),
        .wb_desc     (wb_desc)
    );

    // Accepting a frame's last byte yields an end-of-frame write-back next cycle.
    p_eof_desc_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_ready && byte_eop) |=> (wb_valid && wb_desc[DESC_EOF_BIT]));

    // Every freshly offered write-back carries the done flag.
    p_done_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_valid) |-> wb_desc[DESC_DONE_BIT]);
endmodule

// File: tb/tb_rxd_writer.sv
// Bench: vector table of frames walked by one loop, then directed tests for
// reset, descriptor type gating and mid-frame size change.
module tb_rxd_writer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   gsize_code = 2'd3;
    logic [3:0]   q_bsize = 4'd0;
    logic [2:0]   q_dtype = 3'b000;
    logic         byte_valid = 1'b0;
    logic         byte_ready;
    logic         byte_sof = 1'b0;
    logic         byte_eop = 1'b0;
    logic [63:0]  buf_addr = '0;
    logic [15:0]  pkt_csum = '0;
    logic [7:0]   rx_err = '0;
    logic [15:0]  rx_vlan = '0;
    logic         wb_valid;
    logic         wb_ready = 1'b0;
    logic [127:0] wb_desc;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    rxd_writer #(.QSZ_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .gsize_code(gsize_code), .q_bsize(q_bsize),
        .q_dtype(q_dtype), .byte_valid(byte_valid), .byte_ready(byte_ready),
        .byte_sof(byte_sof), .byte_eop(byte_eop), .buf_addr(buf_addr),
        .pkt_csum(pkt_csum), .rx_err(rx_err), .rx_vlan(rx_vlan),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_desc(wb_desc)
    );

    localparam int NV = 9;
    localparam int V_LEN [NV] = '{600, 512, 1, 257, 1024, 2049, 1500, 2100, 300};
    localparam int V_GC  [NV] = '{3,   2,   3, 3,   1,    0,    3,    3,    0};
    localparam int V_QS  [NV] = '{0,   0,   0, 0,   0,    0,    1,    2,    0};

    // Record one check; print a FAIL line on mismatch.
    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected buffer size from the size inputs (R1, R2).
    function automatic int exp_size(input int gc, input int qs);
        if (qs != 0) return qs * 1024;
        return 2048 >> gc;
    endfunction

    // Send one frame byte by byte and check every write-back it produces.
    task automatic send_frame(input int len, input int sz, input logic [63:0] base,
                              input logic [15:0] csum, input bit swap_size);
        int k = 0;
        int inbuf = 0;
        logic [63:0]  a_k;
        logic [127:0] prev;
        for (int i = 0; i < len; i++) begin
            a_k = base + (64'(k) << 12);
            @(negedge clk);
            byte_valid = 1'b1;
            byte_sof   = (i == 0);
            byte_eop   = (i == len - 1);
            buf_addr   = (inbuf == 0) ? a_k : ~a_k;
            pkt_csum   = csum;
            rx_err     = 8'(8'h40 + k);
            rx_vlan    = 16'(16'h0E00 + k);
            while (!byte_ready) @(negedge clk);
            @(negedge clk);
            byte_valid = 1'b0;
            byte_sof   = 1'b0;
            byte_eop   = 1'b0;
            if (swap_size && i == 0) gsize_code = 2'd0;
            inbuf++;
            if (inbuf == sz || i == len - 1) begin
                chk(wb_valid == 1'b1, "R10 write-back next cycle", 128'(wb_valid), 128'd1);
                chk(wb_desc[79:64] == 16'(inbuf), "R6 length", 128'(wb_desc[79:64]), 128'(inbuf));
                chk(wb_desc[95:80] == ((k == 0) ? csum : 16'h0), "R7 checksum",
                    128'(wb_desc[95:80]), 128'((k == 0) ? csum : 16'h0));
                chk(wb_desc[103:96] == ((i == len - 1) ? 8'h03 : 8'h01), "R8 status",
                    128'(wb_desc[103:96]), 128'((i == len - 1) ? 8'h03 : 8'h01));
                chk(wb_desc[63:0] == a_k, "R9 address", 128'(wb_desc[63:0]), 128'(a_k));
                chk(wb_desc[127:104] == {16'(16'h0E00 + k), 8'(8'h40 + k)}, "R5 err/vlan",
                    128'(wb_desc[127:104]), 128'({16'(16'h0E00 + k), 8'(8'h40 + k)}));
                prev = wb_desc;
                @(negedge clk);
                chk(wb_valid && !byte_ready && wb_desc == prev, "R10 hold while stalled",
                    wb_desc, prev);
                wb_ready = 1'b1;
                @(negedge clk);
                wb_ready = 1'b0;
                chk(!wb_valid && byte_ready, "R10 released", 128'({wb_valid, byte_ready}), 128'b01);
                k++;
                inbuf = 0;
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(wb_valid == 1'b0, "R11 wb_valid after reset", 128'(wb_valid), 128'd0);
        chk(byte_ready == 1'b1, "R11 byte_ready after reset", 128'(byte_ready), 128'd1);

        // Vector table: R1, R2, R5-R10 under several frame lengths and sizes
        for (int v = 0; v < NV; v++) begin
            gsize_code = 2'(V_GC[v]);
            q_bsize    = 4'(V_QS[v]);
            send_frame(V_LEN[v], exp_size(V_GC[v], V_QS[v]),
                       64'h1234_5678_0000_0001 + (64'(v) << 20), 16'(16'hC000 + v), 1'b0);
        end

        // R3: size changed after the first byte must not affect this frame
        gsize_code = 2'd3;
        q_bsize    = 4'd0;
        send_frame(300, 256, 64'h0000_0000_0ABC_0003, 16'hBEEF, 1'b1);

        // R4: non-legacy descriptor type blocks the stream
        q_dtype = 3'b010;
        gsize_code = 2'd3;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            byte_valid = 1'b1;
            byte_sof   = 1'b1;
            byte_eop   = 1'b1;
            @(negedge clk);
            chk(byte_ready == 1'b0 && wb_valid == 1'b0, "R4 non-legacy blocked",
                128'({byte_ready, wb_valid}), 128'b00);
        end
        @(negedge clk);
        byte_valid = 1'b0;
        byte_sof   = 1'b0;
        byte_eop   = 1'b0;
        q_dtype    = 3'b000;
        // R4: nothing was counted while blocked, so a 2-byte frame gives one descriptor of length 2
        send_frame(2, 256, 64'h0000_0000_0000_0007, 16'h1111, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule